// File: doc/BRIEF.md
# Fault-Safe Long-Word Read-Modify-Write Sequencer

This block carries out one 32-bit read-modify-write step on a destination that sits behind a 16-bit data bus and is addressed through a predecremented address register. After a start pulse it lowers the register by four and fetches the two halves of the long word, the high half first at the lower address. It then asks a page-permission port whether each target word may be written. It stores the sum of the old value and a register operand only when every word involved is known to be writable.

When either target word lies in a write-protected page, for example a copy-on-write page, the block stops before any store leaves it. It puts the address register back to its value from before the step and reports a page fault carrying the word address that failed. Because memory is untouched and the register is restored, the fault handler only has to fix the mapping and issue the step again. The result is then applied exactly once.

Top module: `faultsafe_rmw`

## Requirements
- R1: While reset is held low, and in the first cycle after its release, busy, done, fault, memRd, memWr and permReq are all 0.
- R2: A start pulse seen while idle uses an effective address equal to addrRegIn minus 4. On success addrRegOut holds that effective address and done is high for exactly one cycle, after which busy is 0.
- R3: Exactly two bus reads are issued, to the effective address and then to the effective address plus 2, and both come before any permission query.
- R4: With PAGE_BYTES-sized pages, a long word whose two halves fall in different pages causes two permission queries, at the effective address and then at the effective address plus 2. A long word inside one page causes a single query at the effective address.
- R5: On success exactly two writes follow all permission answers. The high half goes to the effective address first, and the low half goes to the effective address plus 2 second.
- R6: The stored long word is the old value (high half from the lower address) plus operand, modulo 2^32.
- R7: If any target word is not writable, no write is issued, memory keeps its contents and addrRegOut returns to addrRegIn.
- R8: On a fault, faultAddr gives the lower-addressed non-writable word, so the high half wins when both halves fail. fault and faultAddr hold steady until faultAck is seen high at a clock edge, after which the block is idle.
- R9: A start pulse while busy or faulted is ignored. It causes no bus reads, and the state that is held, such as faultAddr, stays unchanged.
- R10: Repeating a faulted step after its page has been made writable, with the restored register value, applies the add exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one step (sampled when idle) |
| addrRegIn | input | AW | Address register value before the step |
| operand | input | 32 | Register operand added to memory |
| memAddr | output | AW | Byte address of the current word access |
| memRd | output | 1 | Word read strobe; data returns next cycle |
| memRdata | input | 16 | Read data, valid the cycle after memRd |
| memWr | output | 1 | Word write strobe |
| memWdata | output | 16 | Write data |
| permReq | output | 1 | Permission query strobe |
| permAddr | output | AW | Word address being queried |
| permWritable | input | 1 | Answer, valid the cycle after permReq |
| busy | output | 1 | Step in progress or fault pending |
| done | output | 1 | One-cycle success pulse |
| addrRegOut | output | AW | Address register value after the step |
| fault | output | 1 | Page fault pending |
| faultAddr | output | AW | Address of the faulting word |
| faultAck | input | 1 | Clears a pending fault |

## Verification
The bench builds the block with AW = 24 and PAGE_BYTES = 4096. With these values a register value of 0x20002 makes the long word straddle the page boundary at 0x20000, while 0x30008 keeps both halves in one page. Both the two-query path and the single-query path are therefore reached, and each can be given read-only pages in either half. The bench also re-runs a faulted step after unprotecting the page, which shows that the restored register leads to a single update.

// File: rtl/faultsafe_rmw_pkg.sv
package faultsafe_rmw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEC, S_RD_HI, S_RD_LO, S_CHK_HI, S_CHK_LO,
    S_CHK_END, S_WR_HI, S_WR_LO, S_DONE, S_FAULT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture register and operand at start
    logic dec;      // predecrement working address
    logic capHi;    // capture high read word
    logic capLo;    // capture low read word
    logic capHiOk;  // capture permission answer for the high word
    logic restore;  // roll back address register, latch fault address
    logic faultLo;  // fault lies on the low (address+2) word
    logic selLo;    // address/data select for the low word
  } dpCtrl_t;

endpackage

// File: rtl/faultsafe_rmw_ctrl.sv
module faultsafe_rmw_ctrl
  import faultsafe_rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    permWritable,
  input  logic    hiOk,
  input  logic    crossPage,
  input  logic    faultAck,
  output dpCtrl_t dpCtrl,
  output logic    memRd,
  output logic    memWr,
  output logic    permReq,
  output logic    busy,
  output logic    done,
  output logic    fault
);

  seqState_t state, nextState;
  logic hiVerdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    dpCtrl    = '0;
    memRd     = 1'b0;
    memWr     = 1'b0;
    permReq   = 1'b0;
    hiVerdict = crossPage ? hiOk : permWritable;
    case (state)
      S_IDLE: if (start) begin
        dpCtrl.load = 1'b1;
        nextState   = S_DEC;
      end
      S_DEC: begin
        dpCtrl.dec = 1'b1;
        nextState  = S_RD_HI;
      end
      S_RD_HI: begin
        memRd     = 1'b1;
        nextState = S_RD_LO;
      end
      S_RD_LO: begin
        memRd        = 1'b1;
        dpCtrl.selLo = 1'b1;
        dpCtrl.capHi = 1'b1;
        nextState    = S_CHK_HI;
      end
      S_CHK_HI: begin
        dpCtrl.capLo = 1'b1;
        permReq      = 1'b1;
        nextState    = crossPage ? S_CHK_LO : S_CHK_END;
      end
      S_CHK_LO: begin
        permReq        = 1'b1;
        dpCtrl.selLo   = 1'b1;
        dpCtrl.capHiOk = 1'b1;
        nextState      = S_CHK_END;
      end
      S_CHK_END: begin
        if (!hiVerdict) begin
          dpCtrl.restore = 1'b1;
          nextState      = S_FAULT;
        end else if (!permWritable) begin
          dpCtrl.restore = 1'b1;
          dpCtrl.faultLo = 1'b1;
          nextState      = S_FAULT;
        end else begin
          nextState = S_WR_HI;
        end
      end
      S_WR_HI: begin
        memWr     = 1'b1;
        nextState = S_WR_LO;
      end
      S_WR_LO: begin
        memWr        = 1'b1;
        dpCtrl.selLo = 1'b1;
        nextState    = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      S_FAULT: if (faultAck) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign fault = (state == S_FAULT);

endmodule

// File: rtl/faultsafe_rmw_dp.sv
module faultsafe_rmw_dp
  import faultsafe_rmw_pkg::*;
#(
  parameter int AW         = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dpCtrl_t       dpCtrl,
  input  logic [AW-1:0] addrRegIn,
  input  logic [31:0]   operand,
  input  logic [15:0]   memRdata,
  input  logic          permWritable,
  output logic [AW-1:0] memAddr,
  output logic [15:0]   memWdata,
  output logic [AW-1:0] permAddr,
  output logic [AW-1:0] addrRegOut,
  output logic [AW-1:0] faultAddr,
  output logic          hiOk,
  output logic          crossPage
);

  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  logic [AW-1:0] aReg, savedA, addrLo, addrSel, faultAddrR;
  logic [31:0]   opnd, sum;
  logic [15:0]   hiWord, loWord;

  assign addrLo  = aReg + AW'(2);
  assign addrSel = dpCtrl.selLo ? addrLo : aReg;
  assign sum     = {hiWord, loWord} + opnd;   // carry-out dropped

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg       <= '0;
      savedA     <= '0;
      opnd       <= '0;
      hiWord     <= '0;
      loWord     <= '0;
      hiOk       <= 1'b0;
      faultAddrR <= '0;
    end else begin
      if (dpCtrl.load) begin
        aReg   <= addrRegIn;
        savedA <= addrRegIn;
        opnd   <= operand;
      end
      if (dpCtrl.dec)     aReg   <= aReg - AW'(4);
      if (dpCtrl.capHi)   hiWord <= memRdata;
      if (dpCtrl.capLo)   loWord <= memRdata;
      if (dpCtrl.capHiOk) hiOk   <= permWritable;
      if (dpCtrl.restore) begin
        aReg       <= savedA;
        faultAddrR <= dpCtrl.faultLo ? addrLo : aReg;
      end
    end
  end

  assign crossPage  = aReg[AW-1:PAGE_SHIFT] != addrLo[AW-1:PAGE_SHIFT];
  assign memAddr    = addrSel;
  assign permAddr   = addrSel;
  assign memWdata   = dpCtrl.selLo ? sum[15:0] : sum[31:16];
  assign addrRegOut = aReg;
  assign faultAddr  = faultAddrR;

endmodule

// File: rtl/faultsafe_rmw.sv
module faultsafe_rmw
  import faultsafe_rmw_pkg::*;
#(
  parameter int AW         = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addrRegIn,
  input  logic [31:0]   operand,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  input  logic [15:0]   memRdata,
  output logic          memWr,
  output logic [15:0]   memWdata,
  output logic          permReq,
  output logic [AW-1:0] permAddr,
  input  logic          permWritable,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addrRegOut,
  output logic          fault,
  output logic [AW-1:0] faultAddr,
  input  logic          faultAck
);

  dpCtrl_t dpCtrl;
  logic    hiOk, crossPage;

  faultsafe_rmw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .permWritable(permWritable),
    .hiOk(hiOk), .crossPage(crossPage), .faultAck(faultAck),
    .dpCtrl(dpCtrl), .memRd(memRd), .memWr(memWr), .permReq(permReq),
    .busy(busy), .done(done), .fault(fault)
  );

  faultsafe_rmw_dp #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl), .addrRegIn(addrRegIn),
    .operand(operand), .memRdata(memRdata), .permWritable(permWritable),
    .memAddr(memAddr), .memWdata(memWdata), .permAddr(permAddr),
    .addrRegOut(addrRegOut), .faultAddr(faultAddr), .hiOk(hiOk),
    .crossPage(crossPage)
  );

endmodule

// File: rtl/faultsafe_rmw_chk.sv
module faultsafe_rmw_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] addrRegIn,
  input logic [AW-1:0] memAddr,
  input logic          memRd,
  input logic          memWr,
  input logic          permReq,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [AW-1:0] faultAddr,
  input logic          faultAck,
  input logic [AW-1:0] addrRegOut
);

  logic [AW-1:0] startA;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               startA <= '0;
    else if (start && !busy)  startA <= addrRegIn;
  end

  // R1: idle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !memRd && !memWr && !permReq && !fault && !done);

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R3: the second read follows at address+2
  a_r3_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memRd) |=> memRd && memAddr == $past(memAddr) + AW'(2));

  // R5: no write shares a cycle with a read or a query
  a_r5_write_alone: assert property (@(posedge clk) disable iff (!rst_n)
    memWr |-> !memRd && !permReq);

  // R7: no write while a fault is pending; register rolled back
  a_r7_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !memWr);
  a_r7_register_restored: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> addrRegOut == startA);

  // R8: fault and its address hold until acknowledged
  a_r8_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !faultAck |=> fault && $stable(faultAddr));

endmodule

bind faultsafe_rmw faultsafe_rmw_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addrRegIn(addrRegIn),
  .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .permReq(permReq),
  .busy(busy), .done(done), .fault(fault), .faultAddr(faultAddr),
  .faultAck(faultAck), .addrRegOut(addrRegOut)
);

// File: tb/faultsafe_rmw_bench.sv
`timescale 1ns/1ps
module faultsafe_rmw_bench;
  localparam int AW = 24;
  localparam int PSH = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, faultAck = 1'b0;
  logic [AW-1:0] addrRegIn = '0;
  logic [31:0]   operand = '0;
  logic [AW-1:0] memAddr, permAddr, addrRegOut, faultAddr;
  logic          memRd, memWr, permReq, busy, done, fault;
  logic [15:0]   memWdata, memRdata;
  logic          permWritable;

  always #2.5 clk = ~clk;

  faultsafe_rmw #(.AW(AW), .PAGE_BYTES(4096)) u_faultsafe_rmw (
    .clk(clk), .rst_n(rst_n), .start(start), .addrRegIn(addrRegIn),
    .operand(operand), .memAddr(memAddr), .memRd(memRd), .memRdata(memRdata),
    .memWr(memWr), .memWdata(memWdata), .permReq(permReq), .permAddr(permAddr),
    .permWritable(permWritable), .busy(busy), .done(done),
    .addrRegOut(addrRegOut), .fault(fault), .faultAddr(faultAddr),
    .faultAck(faultAck)
  );

  // memory, permission model and activity logs
  logic [15:0] memArr [int unsigned];
  bit          roPage [int unsigned];
  int unsigned rdLog[$], permLog[$], wrLog[$];
  logic [15:0] rdQ = '0;
  logic        permQ = 1'b0;
  int nTests = 0, nFail = 0;

  function automatic logic [15:0] rdMem(int unsigned a);
    return memArr.exists(a) ? memArr[a] : 16'h0;
  endfunction

  assign memRdata     = rdQ;
  assign permWritable = permQ;

  always @(posedge clk) begin
    if (memRd) begin rdQ <= rdMem(memAddr); rdLog.push_back(memAddr); end
    if (permReq) begin
      permQ <= !roPage.exists(int'(permAddr) >> PSH);
      permLog.push_back(permAddr);
    end
    if (memWr) begin memArr[memAddr] = memWdata; wrLog.push_back(memAddr); end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    rdLog.delete(); permLog.delete(); wrLog.delete();
  endtask

  // issue one step and wait for done or fault
  task automatic runOp(input logic [AW-1:0] a, input logic [31:0] op);
    clearLogs();
    @(negedge clk); addrRegIn = a; operand = op; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 40 && !done && !fault; i++) @(negedge clk);
  endtask

  task automatic ackFault();
    faultAck = 1'b1; @(negedge clk); faultAck = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "outputs", {done, fault, memRd, memWr, permReq}, 0);
  endtask

  task automatic t_crossOk();
    memArr[32'h1FFFE] = 16'h1234; memArr[32'h20000] = 16'hFFFF;
    runOp(24'h020002, 32'h0000_0001);
    chk("R2", "done", done, 1);
    chk("R2", "addrRegOut", addrRegOut, 32'h1FFFE);
    chk("R3", "read count", rdLog.size(), 2);
    chk("R3", "first read", rdLog[0], 32'h1FFFE);
    chk("R3", "second read", rdLog[1], 32'h20000);
    chk("R4", "query count", permLog.size(), 2);
    chk("R4", "query order", {permLog[0][15:0], permLog[1][15:0]}, 32'hFFFE_0000);
    chk("R5", "write count", wrLog.size(), 2);
    chk("R5", "write order", {wrLog[0][15:0], wrLog[1][15:0]}, 32'hFFFE_0000);
    chk("R6", "sum", {rdMem(32'h1FFFE), rdMem(32'h20000)}, 32'h1235_0000);
    @(negedge clk);
    chk("R2", "done pulse", {done, busy}, 0);
  endtask

  task automatic t_crossLoRo();
    memArr[32'h1FFFE] = 16'hAAAA; memArr[32'h20000] = 16'h5555;
    roPage[32'h20] = 1'b1;
    runOp(24'h020002, 32'h0001_0001);
    chk("R8", "fault", fault, 1);
    chk("R8", "faultAddr lo", faultAddr, 32'h20000);
    chk("R7", "no writes", wrLog.size(), 0);
    chk("R7", "memory", {rdMem(32'h1FFFE), rdMem(32'h20000)}, 32'hAAAA_5555);
    chk("R7", "addr restored", addrRegOut, 32'h20002);
    repeat (3) @(negedge clk);
    chk("R8", "held", {fault, faultAddr[15:0]}, {1'b1, 16'h0000});
    ackFault();
    chk("R8", "ack idle", {busy, fault}, 0);
  endtask

  task automatic t_crossHiRo();
    roPage.delete(); roPage[32'h1F] = 1'b1;
    memArr[32'h1FFFE] = 16'h0101; memArr[32'h20000] = 16'h0202;
    runOp(24'h020002, 32'h1);
    chk("R8", "faultAddr hi", faultAddr, 32'h1FFFE);
    chk("R7", "no writes hi", wrLog.size(), 0);
    ackFault();
    roPage[32'h20] = 1'b1;  // both pages protected: high wins
    runOp(24'h020002, 32'h1);
    chk("R8", "both ro priority", faultAddr, 32'h1FFFE);
    ackFault();
  endtask

  task automatic t_samePage();
    roPage.delete();
    memArr[32'h30004] = 16'hFFFF; memArr[32'h30006] = 16'hFFFF;
    runOp(24'h030008, 32'h0000_0002);
    chk("R4", "single query", permLog.size(), 1);
    chk("R4", "query addr", permLog[0], 32'h30004);
    chk("R6", "carry dropped", {rdMem(32'h30004), rdMem(32'h30006)}, 32'h0000_0001);
    chk("R2", "addrRegOut same", addrRegOut, 32'h30004);
    roPage[32'h30] = 1'b1;
    runOp(24'h030008, 32'h5);
    chk("R8", "same page fault", faultAddr, 32'h30004);
    chk("R7", "same page no write", wrLog.size(), 0);
    ackFault();
  endtask

  task automatic t_ignoreStart();
    roPage.delete(); roPage[32'h20] = 1'b1;
    runOp(24'h020002, 32'h1);
    clearLogs();
    @(negedge clk); addrRegIn = 24'h050000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "fault kept", {fault, faultAddr[15:0]}, {1'b1, 16'h0000});
    chk("R9", "no reads", rdLog.size(), 0);
    ackFault();
  endtask

  task automatic t_reexec();
    logic [AW-1:0] back;
    roPage.delete(); roPage[32'h20] = 1'b1;
    memArr[32'h1FFFE] = 16'h0000; memArr[32'h20000] = 16'hFFFF;
    runOp(24'h020002, 32'h0000_0001);
    back = addrRegOut;
    ackFault();
    roPage.delete();
    runOp(back, 32'h0000_0001);
    chk("R10", "single update", {rdMem(32'h1FFFE), rdMem(32'h20000)}, 32'h0001_0000);
    chk("R10", "done", done, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crossOk();
    t_crossLoRo();
    t_crossHiRo();
    t_samePage();
    t_ignoreStart();
    t_reexec();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule